// File: doc/BRIEF.md
# Software-Managed Page Translation Buffer

This block is a small, fully associative translation buffer that system software fills and maintains by hand. Software stages a candidate entry in a group of staging registers: the page-pair tag with its address-space ID, the page-size mask, and one frame descriptor for each of the two pages. It then issues one of four maintenance commands: write at a chosen slot, write at a pseudo-random slot, search for an entry that matches the staged tag, or read a slot back into the staging registers. Each command takes one clock cycle. There is no handshake.

Each entry covers an even/odd pair of pages. Each page has its own frame number, valid, dirty and cache-attribute bits. An entry matches when its tag agrees with the address under the page-size mask and one of two conditions holds: its global bit is set, or its address-space ID equals the current one. The block has a separate combinational lookup port. It turns a virtual address into a physical address together with hit, valid and dirty flags. A core's load/store path uses this port, and a miss or an invalid page there raises a refill exception in the core. The parameter `N` sets the number of entries, from 2 to 64. A read-only configuration word reports the count in the form "entries minus one".

Top module: `pagemap_tlb`

## Requirements
- R1: While reset is asserted, every register reads zero except two. The random slot register reads N-1. The configuration register (address 6) reads N-1 in bits [5:0]. All entries are cleared, so an address in the lowest page pair with address-space ID 0 hits entry 0 and returns frame 0 with valid and dirty both 0.
- R2: The register map uses these addresses. 0: slot register, where bits [5:0] are writable and bit 31 is a read-only probe-failure flag that a write clears. 1: random slot, read-only. 2: even-page descriptor, bits [25:0] kept. 3: odd-page descriptor, bits [25:0] kept. 4: page-size mask, bits [24:13] kept. 5: tag register, bits [31:13] and [7:0] kept. 6: configuration, read-only. Bits that are not kept read as zero.
- R3: The random slot register counts down by one on every clock after reset and wraps from 0 to N-1. Register writes do not affect it.
- R4: Command 0 (indexed write) stores the staged entry at slot (slot register bits [5:0]) modulo N. The stored global bit is the AND of bit 0 of the two descriptors.
- R5: Command 1 (random write) stores the staged entry at the slot held by the random register in the cycle the command is issued.
- R6: Command 3 (indexed read) loads the staging registers from slot (bits [5:0]) modulo N. The tag register gets the tag in [31:13] and the stored ID in [7:0]. The mask is restored. Each descriptor is rebuilt as global in [0], valid in [1], dirty in [2], cache attribute in [5:3] and frame number in [25:6].
- R7: A lookup hits only when both conditions hold: the entry is global or its ID equals tag register bits [7:0], and the address agrees with the stored tag outside the mask. On a miss, the physical address, valid and dirty outputs are all zero.
- R8: The address bit just above the page offset selects the page. A 1 selects the odd descriptor and a 0 selects the even one. The physical address is the frame number shifted left by 12 bits, with the offset bits taken from the virtual address.
- R9: Mask bits [24:13] widen the page. The comparison mask is the mask ORed with 0x1FFF, so the smallest pair spans 8 KB and each mask bit doubles the page size.
- R10: Command 2 (probe) compares the staged tag and ID against all entries. On a match it writes the lowest matching slot number to the slot register and clears bit 31.
- R11: When a probe finds no match, it sets bit 31 of the slot register.
- R12: When several entries match a lookup, the lowest-numbered entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| cmd_valid | input | 1 | Issue a maintenance command this cycle |
| cmd_op | input | 2 | Command code: 0 indexed write, 1 random write, 2 probe, 3 indexed read |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Some entry matches lk_va |
| lk_pa | output | 32 | Translated physical address |
| lk_valid | output | 1 | Valid bit of the selected page |
| lk_dirty | output | 1 | Dirty bit of the selected page |

## Verification
The hardest situation to create is a random write that lands in a known slot, because the random register runs freely on every clock. The bench reads the random register in the same cycle it issues the command. It issues the command only when that value is not a slot it has already filled. It then probes with the same tag to confirm the slot. Wide pages need a separate path: the odd-page select bit moves and some frame bits fall inside the page offset, so the bench loads an entry with a four-times mask and translates addresses on both sides of the moved select bit and just past the pair.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;

    typedef enum logic [1:0] {
        CMD_WR_IDX = 2'd0,
        CMD_WR_RND = 2'd1,
        CMD_PROBE  = 2'd2,
        CMD_RD_IDX = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        RA_SLOT  = 3'd0,
        RA_RAND  = 3'd1,
        RA_EVEN  = 3'd2,
        RA_ODD   = 3'd3,
        RA_MASK  = 3'd4,
        RA_TAG   = 3'd5,
        RA_CONF  = 3'd6,
        RA_NONE  = 3'd7
    } raddr_e;

    localparam logic [31:0] TAG_KEEP  = 32'hFFFF_E0FF;
    localparam logic [31:0] MASK_KEEP = 32'h01FF_E000;
    localparam logic [31:0] DESC_KEEP = 32'h03FF_FFFF;

    typedef struct packed {
        logic [19:0] frame;
        logic [2:0]  cattr;
        logic        dirty;
        logic        valid;
    } page_t;

    typedef struct packed {
        logic [18:0] vtag;
        logic [7:0]  asid;
        logic [11:0] pmask;
        logic        glob;
        page_t       even;
        page_t       odd;
    } slot_t;

    function automatic page_t desc_to_page(input logic [31:0] d);
        page_t p;
        p.frame = d[25:6];
        p.cattr = d[5:3];
        p.dirty = d[2];
        p.valid = d[1];
        return p;
    endfunction

    function automatic logic [31:0] page_to_desc(input page_t p, input logic g);
        return {6'b0, p.frame, p.cattr, p.dirty, p.valid, g};
    endfunction

    function automatic logic [31:0] cmp_mask(input logic [11:0] pm);
        return {7'b0, pm, 13'h1FFF};
    endfunction

endpackage

// File: rtl/pm_match.sv
module pm_match
    import pagemap_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  slot_t [N-1:0] slots,
    input  logic [31:0]   key_va,
    input  logic [7:0]    key_asid,
    output logic          any_hit,
    output logic [IW-1:0] first_idx
);
    logic [N-1:0] hits;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [31:0] m;
        logic        tag_ok;
        logic        id_ok;
        assign m      = cmp_mask(slots[i].pmask);
        assign tag_ok = ((key_va ^ {slots[i].vtag, 13'b0}) & ~m) == 32'b0;
        assign id_ok  = slots[i].glob || (slots[i].asid == key_asid);
        assign hits[i] = tag_ok && id_ok;
    end

    always_comb begin
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) first_idx = IW'(i);
        end
    end

    assign any_hit = |hits;
endmodule

// File: rtl/pm_store.sv
module pm_store
    import pagemap_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  slot_t         wdata,
    output slot_t [N-1:0] slots
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (we && widx == IW'(i)) begin
                slots[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pagemap_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          probe_any,
    input  logic [IW-1:0] probe_idx,
    input  slot_t         rd_slot,
    output logic [5:0]    slot_field,
    output logic          slot_fail,
    output logic [IW-1:0] rnd,
    output logic [31:0]   tag_r,
    output logic [31:0]   mask_r,
    output logic [31:0]   even_r,
    output logic [31:0]   odd_r
);
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd        <= TOP;
            slot_field <= '0;
            slot_fail  <= 1'b0;
            tag_r      <= '0;
            mask_r     <= '0;
            even_r     <= '0;
            odd_r      <= '0;
        end else begin
            rnd <= (rnd == '0) ? TOP : rnd - 1'b1;
            if (reg_wr) begin
                case (raddr_e'(reg_addr))
                    RA_SLOT: begin
                        slot_field <= reg_wdata[5:0];
                        slot_fail  <= 1'b0;
                    end
                    RA_EVEN: even_r <= reg_wdata & DESC_KEEP;
                    RA_ODD:  odd_r  <= reg_wdata & DESC_KEEP;
                    RA_MASK: mask_r <= reg_wdata & MASK_KEEP;
                    RA_TAG:  tag_r  <= reg_wdata & TAG_KEEP;
                    default: ;
                endcase
            end
            if (cmd_valid) begin
                case (cmd_e'(cmd_op))
                    CMD_PROBE: begin
                        slot_fail <= !probe_any;
                        if (probe_any) slot_field <= 6'(probe_idx);
                    end
                    CMD_RD_IDX: begin
                        tag_r  <= {rd_slot.vtag, 5'b0, rd_slot.asid};
                        mask_r <= {7'b0, rd_slot.pmask, 13'b0};
                        even_r <= page_to_desc(rd_slot.even, rd_slot.glob);
                        odd_r  <= page_to_desc(rd_slot.odd, rd_slot.glob);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (raddr_e'(reg_addr))
            RA_SLOT: reg_rdata = {slot_fail, 25'b0, slot_field};
            RA_RAND: reg_rdata = 32'(rnd);
            RA_EVEN: reg_rdata = even_r;
            RA_ODD:  reg_rdata = odd_r;
            RA_MASK: reg_rdata = mask_r;
            RA_TAG:  reg_rdata = tag_r;
            RA_CONF: reg_rdata = {26'b0, 6'(N - 1)};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pagemap_tlb.sv
module pagemap_tlb
    import pagemap_pkg::*;
#(
    parameter int N = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic        lk_valid,
    output logic        lk_dirty
);
    localparam int IW = $clog2(N);

    logic [5:0]    slot_field;
    logic          slot_fail;
    logic [IW-1:0] rnd_q;
    logic [31:0]   tag_r, mask_r, even_r, odd_r;
    slot_t [N-1:0] slots;
    slot_t         staged;
    slot_t         rd_slot;
    logic [IW-1:0] sel_idx;
    logic          probe_any;
    logic [IW-1:0] probe_idx;
    logic          look_any;
    logic [IW-1:0] look_idx;
    logic          we;
    logic [IW-1:0] widx;

    assign sel_idx = IW'(int'(slot_field) % N);

    pm_regs #(.N(N)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .probe_any(probe_any), .probe_idx(probe_idx), .rd_slot(rd_slot),
        .slot_field(slot_field), .slot_fail(slot_fail), .rnd(rnd_q),
        .tag_r(tag_r), .mask_r(mask_r), .even_r(even_r), .odd_r(odd_r)
    );

    always_comb begin
        staged.vtag  = tag_r[31:13];
        staged.asid  = tag_r[7:0];
        staged.pmask = mask_r[24:13];
        staged.glob  = even_r[0] & odd_r[0];
        staged.even  = desc_to_page(even_r);
        staged.odd   = desc_to_page(odd_r);
    end

    assign we   = cmd_valid && (cmd_op == CMD_WR_IDX || cmd_op == CMD_WR_RND);
    assign widx = (cmd_op == CMD_WR_RND) ? rnd_q : sel_idx;

    pm_store #(.N(N)) u_store (
        .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(staged), .slots(slots)
    );

    assign rd_slot = slots[sel_idx];

    pm_match #(.N(N)) u_probe (
        .slots(slots), .key_va(tag_r), .key_asid(tag_r[7:0]),
        .any_hit(probe_any), .first_idx(probe_idx)
    );

    pm_match #(.N(N)) u_look (
        .slots(slots), .key_va(lk_va), .key_asid(tag_r[7:0]),
        .any_hit(look_any), .first_idx(look_idx)
    );

    slot_t       hit_slot;
    logic [31:0] off_mask;
    logic        odd_sel;
    page_t       pg;

    always_comb begin
        hit_slot = slots[look_idx];
        off_mask = cmp_mask(hit_slot.pmask) >> 1;
        odd_sel  = |(lk_va & (off_mask + 32'd1));
        pg       = odd_sel ? hit_slot.odd : hit_slot.even;
        lk_hit   = look_any;
        lk_pa    = '0;
        lk_valid = 1'b0;
        lk_dirty = 1'b0;
        if (look_any) begin
            lk_pa    = ({pg.frame, 12'b0} & ~off_mask) | (lk_va & off_mask);
            lk_valid = pg.valid;
            lk_dirty = pg.dirty;
        end
    end
endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pagemap_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [IW-1:0] rnd,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          probe_any,
    input logic          slot_fail,
    input logic          lk_hit,
    input logic [31:0]   lk_pa,
    input logic          lk_valid,
    input logic          lk_dirty
);
    assert_random_range_R3: assert property (@(posedge clk) disable iff (rst)
        int'(rnd) < N);

    assert_random_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rnd != '0) |=> (rnd == $past(rnd) - 1'b1));

    assert_random_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (rnd == '0) |=> (int'(rnd) == N - 1));

    assert_probe_hit_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_PROBE && probe_any) |=> !slot_fail);

    assert_probe_miss_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_PROBE && !probe_any) |=> slot_fail);

    assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == 32'b0 && !lk_valid && !lk_dirty));
endmodule

bind pagemap_tlb pm_checker #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .rnd(rnd_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .probe_any(probe_any), .slot_fail(slot_fail), .lk_hit(lk_hit),
    .lk_pa(lk_pa), .lk_valid(lk_valid), .lk_dirty(lk_dirty)
);

// File: tb/sim_pagemap_tlb.sv
module sim_pagemap_tlb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_valid;
    logic        lk_dirty;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pagemap_tlb #(.N(N)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_valid(lk_valid), .lk_dirty(lk_dirty)
    );

    // {tag reg, va, hit, pa, valid, dirty}
    localparam int NV = 11;
    localparam logic [98:0] VEC [NV] = '{
        {32'h0000_0005, 32'h0040_2ABC, 1'b1, 32'h1234_5ABC, 1'b1, 1'b1},
        {32'h0000_0005, 32'h0040_3123, 1'b1, 32'h00AB_C123, 1'b1, 1'b0},
        {32'h0000_0006, 32'h0040_2ABC, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_0033, 32'h8000_1234, 1'b1, 32'h4000_1234, 1'b1, 1'b0},
        {32'h0000_0033, 32'h8000_7FFF, 1'b1, 32'h4000_7FFF, 1'b1, 1'b1},
        {32'h0000_0033, 32'h8000_8000, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_0005, 32'h00AB_C010, 1'b1, 32'h0011_1010, 1'b1, 1'b0},
        {32'h0000_0005, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_0000, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, 1'b0},
        {32'h0000_0005, 32'h1234_4010, 1'b1, 32'h0777_7010, 1'b1, 1'b0},
        {32'h0000_0077, 32'h1234_4010, 1'b0, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stage(input logic [31:0] t, input logic [31:0] m,
                         input logic [31:0] e, input logic [31:0] o);
        wreg(3'd5, t); wreg(3'd4, m); wreg(3'd2, e); wreg(3'd3, o);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        logic [31:0] rw_slot;
        bit placed;

        // R1: reset state, observed while reset is held
        repeat (3) @(negedge clk);
        rreg(3'd0, v); check("R1 slot", v, 32'h0);
        rreg(3'd1, v); check("R1 random", v, 32'(N - 1));
        rreg(3'd2, v); check("R1 even", v, 32'h0);
        rreg(3'd3, v); check("R1 odd", v, 32'h0);
        rreg(3'd4, v); check("R1 mask", v, 32'h0);
        rreg(3'd5, v); check("R1 tag", v, 32'h0);
        rreg(3'd6, v); check("R1 config", v, 32'(N - 1));
        lk_va = 32'h0000_0100; #1;
        check("R1 reset lookup", {lk_hit, lk_valid, lk_dirty, 29'b0}, {1'b1, 31'b0});
        check("R1 reset pa", lk_pa, 32'h0000_0100);
        @(negedge clk); rst = 1'b0;

        // R2: kept bits and read-only registers
        wreg(3'd5, 32'hFFFF_FFFF); rreg(3'd5, v); check("R2 tag", v, 32'hFFFF_E0FF);
        wreg(3'd4, 32'hFFFF_FFFF); rreg(3'd4, v); check("R2 mask", v, 32'h01FF_E000);
        wreg(3'd2, 32'hFFFF_FFFF); rreg(3'd2, v); check("R2 even", v, 32'h03FF_FFFF);
        wreg(3'd3, 32'hFFFF_FFFF); rreg(3'd3, v); check("R2 odd", v, 32'h03FF_FFFF);
        wreg(3'd0, 32'hFFFF_FFFF); rreg(3'd0, v); check("R2 slot", v, 32'h0000_003F);
        wreg(3'd6, 32'h0000_0000); rreg(3'd6, v); check("R2 config ro", v, 32'(N - 1));
        // R3: random write ignored, count continues
        @(negedge clk);
        rreg(3'd1, prev);
        reg_wr = 1'b1; reg_wdata = 32'h0000_0005;
        @(negedge clk);
        reg_wr = 1'b0;
        rreg(3'd1, v);
        check("R3 random write ignored", v, (prev == 0) ? 32'(N - 1) : prev - 1);
        stage(32'h0, 32'h0, 32'h0, 32'h0);
        wreg(3'd0, 32'h0);

        // R3: countdown with wrap over more than one period
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rreg(3'd1, v);
            if (k > 0) check("R3 random step", v, (prev == 0) ? 32'(N - 1) : prev - 1);
            prev = v;
        end

        // R4: indexed writes, slot 23 wraps to 7
        stage(32'h0040_2005, 32'h0, 32'h0048_D156, 32'h0002_AF03);
        wreg(3'd0, 32'd3); cmd(2'd0);
        stage(32'h8000_0009, 32'h0000_6000, 32'h0100_0003, 32'h0100_0107);
        wreg(3'd0, 32'd23); cmd(2'd0);
        stage(32'h00AB_C005, 32'h0, 32'h0000_4442, 32'h0);
        wreg(3'd0, 32'd5); cmd(2'd0);
        wreg(3'd2, 32'h0000_8886);
        wreg(3'd0, 32'd9); cmd(2'd0);

        // R5: random write into a free slot
        stage(32'h1234_4005, 32'h0, 32'h001D_DDC2, 32'h0);
        placed = 0;
        rw_slot = '0;
        for (int k = 0; k < 64 && !placed; k++) begin
            @(negedge clk);
            rreg(3'd1, v);
            if (v != 0 && v != 3 && v != 5 && v != 7 && v != 9) begin
                cmd_valid = 1'b1; cmd_op = 2'd1;
                rw_slot = v;
                placed = 1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        end
        cmd(2'd2);
        rreg(3'd0, v); check("R5 random slot", v, rw_slot);

        // R10/R11: probes
        wreg(3'd5, 32'h0040_2005); cmd(2'd2);
        rreg(3'd0, v); check("R10 probe slot3", v, 32'd3);
        wreg(3'd5, 32'h8000_1009); cmd(2'd2);
        rreg(3'd0, v); check("R4 R10 probe global wide", v, 32'd7);
        wreg(3'd5, 32'h00AB_C005); cmd(2'd2);
        rreg(3'd0, v); check("R10 probe lowest of 5,9", v, 32'd5);
        wreg(3'd5, 32'h0000_0000); cmd(2'd2);
        rreg(3'd0, v); check("R10 probe lowest zero slot", v, 32'd0);
        wreg(3'd5, 32'h0040_2006); cmd(2'd2);
        rreg(3'd0, v); check("R11 probe miss flag", {31'b0, v[31]}, 32'd1);

        // R6: indexed read of slot 23 mod N
        wreg(3'd0, 32'd23); cmd(2'd3);
        rreg(3'd5, v); check("R6 read tag", v, 32'h8000_0009);
        rreg(3'd4, v); check("R6 read mask", v, 32'h0000_6000);
        rreg(3'd2, v); check("R6 read even", v, 32'h0100_0003);
        rreg(3'd3, v); check("R6 read odd", v, 32'h0100_0107);
        wreg(3'd0, 32'd3); cmd(2'd3);
        rreg(3'd2, v); check("R4 R6 non-global read", v, 32'h0048_D156);

        // R7 R8 R9 R12: lookup vector table
        for (int i = 0; i < NV; i++) begin
            wreg(3'd5, VEC[i][98:67]);
            lk_va = VEC[i][66:35];
            #1;
            check($sformatf("R7 R12 hit vec%0d", i), {31'b0, lk_hit}, {31'b0, VEC[i][34]});
            check($sformatf("R8 R9 pa vec%0d", i), lk_pa, VEC[i][33:2]);
            check($sformatf("R8 flags vec%0d", i), {30'b0, lk_valid, lk_dirty}, {30'b0, VEC[i][1:0]});
        end

        finish_run();
    end
endmodule